// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects twenty-eight interrupt requests and presents them to a processor as two exception lines. Nine requests arrive from package pins: one fast line and eight general lines. These are active-low. They are synchronized, and each falling edge is captured in a pending bit that software clears. The other nineteen requests come from on-chip peripherals. They are level-sensitive and show as pending for as long as they are raised.

Every source carries a 3-bit priority level, where 0 disables the source. The general lines and the peripheral requests compete for the IRQ output. The winner is the pending enabled source with the highest level, and a tie goes to the lowest source number. IRQ is raised only when the winner's level exceeds the current level.

The fast pin is kept out of that competition and drives the FIQ output by itself. Software reads a number register to learn which source won and to acknowledge it. The acknowledge raises the current level to the winner's level and saves the old level in a one-deep slot. A write to the same register puts the saved level back. All registers sit on a simple word-addressed bus: the read data is combinational from the address, and side effects occur on the clock edge where the read or write strobe is high.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq and fiq are low, the current level is 0, all pending bits read 0 and the number register reads 31.
- R2: Source numbers are fixed: the fast pin is 0, general pin k (ext_req_n[k]) is 1+k, and peripheral request j (int_req[j]) is 9+j. Bit n of the pending register (address 4, bits 27:0) belongs to source n.
- R3: The level of source s sits in word s/8 (addresses 0 to 3), bits [4*(s%8)+2 : 4*(s%8)]. It is written and read there, and level 0 disables the source.
- R4: Among pending sources 1 to 27 with non-zero level, the highest level wins and a tie goes to the lowest number. The number register (address 5) reads the winner's number while irq is high and 31 otherwise.
- R5: irq is high exactly when a winner exists and its level is greater than the current level (address 6, bits 2:0).
- R6: A read strobe at address 5 while irq is high sets the current level to the winner's level on that edge and saves the prior current level. A read strobe while irq is low changes nothing.
- R7: A write strobe at address 5 restores the current level from the saved slot and clears the slot to 0. The written data is ignored.
- R8: A falling edge on an external pin sets its pending bit on the third rising clock edge after the pin changes. A pin held low does not set the bit again after it is cleared.
- R9: Writing 1 to a pending bit of sources 0 to 8 clears it, and writing 0 leaves it unchanged. If an edge capture and a clear fall on the same edge, the bit stays set.
- R10: fiq is high exactly when source 0 is pending and its level is non-zero. Source 0 never becomes the IRQ winner.
- R11: Pending bits 9 to 27 follow int_req directly, and writes to the pending register do not affect them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fast_req_n | input | 1 | Active-low fast request pin (source 0) |
| ext_req_n | input | 8 | Active-low general request pins (sources 1 to 8) |
| int_req | input | 19 | Active-high peripheral requests (sources 9 to 27) |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (acknowledge side effect at address 5) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Normal interrupt request to the processor |
| fiq | output | 1 | Fast interrupt request to the processor |

## Verification
Two functions can land on the same clock edge. One is the capture of a pin's falling edge into its pending bit. The other is a software write-one clear of that same bit. The bench lowers a pin, counts the synchronizer stages, and places the clear strobe on the exact edge where the capture lands. It then expects the bit to stay set, and it checks that a second clear removes the bit. Arbitration is judged against a bench model of levels, pending bits and current level under random level maps and request patterns, and directed cases cover ties, disabled sources, acknowledge and restore.

// File: rtl/prio_intc_pkg.sv
// Shared declarations for the prioritized interrupt controller.
// Assumes a word-addressed register bus with at most eight words.
package prio_intc_pkg;

    // Decoded register kind selected by the bus address.
    typedef enum logic [2:0] {
        RK_LEVEL = 3'd0,
        RK_PEND  = 3'd1,
        RK_NUM   = 3'd2,
        RK_CUR   = 3'd3,
        RK_NONE  = 3'd4
    } reg_kind_t;

endpackage

// File: rtl/icu_edge_capture.sv
// Edge capture for active-low request pins.
// Each pin goes through a two-stage synchronizer plus a history stage.
// A high-to-low transition sets a sticky pending bit. A clear strobe
// resets the bit unless a new edge lands on the same clock.
// Assumes the pins are asynchronous to clk.
module icu_edge_capture #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_n,
    input  logic [N-1:0] clr,
    output logic [N-1:0] fall,
    output logic [N-1:0] pend
);

    logic [N-1:0] s1_q;
    logic [N-1:0] s2_q;
    logic [N-1:0] s3_q;

    for (genvar i = 0; i < N; i++) begin : g_line
        // Synchronize the pin and keep one cycle of history (idle high).
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q[i] <= 1'b1;
                s2_q[i] <= 1'b1;
                s3_q[i] <= 1'b1;
            end else begin
                s1_q[i] <= req_n[i];
                s2_q[i] <= s1_q[i];
                s3_q[i] <= s2_q[i];
            end
        end

        // A synchronized high-to-low step marks a new request.
        assign fall[i] = s3_q[i] & ~s2_q[i];

        // Sticky pending bit: an edge has priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else begin
                pend[i] <= fall[i] | (pend[i] & ~clr[i]);
            end
        end
    end

endmodule

// File: rtl/icu_arbiter.sv
// Priority selection over the pending sources.
// It scans sources FIRST to N_SRC-1 and keeps the highest non-zero level.
// A tie is resolved toward the lower source number. Purely combinational.
// Assumes levels arrive packed LVL_W bits per source, source 0 at the bottom.
module icu_arbiter #(
    parameter int N_SRC = 28,
    parameter int LVL_W = 3,
    parameter int NUM_W = 5,
    parameter int FIRST = 1
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] lvl,
    output logic                   win_vld,
    output logic [NUM_W-1:0]       win_num,
    output logic [LVL_W-1:0]       win_lvl
);

    // Downward scan with >= so the lowest index among equals is kept.
    always_comb begin
        win_vld = 1'b0;
        win_num = '0;
        win_lvl = '0;
        for (int i = N_SRC - 1; i >= FIRST; i--) begin
            if (req[i] && (lvl[i*LVL_W +: LVL_W] != '0)
                       && (lvl[i*LVL_W +: LVL_W] >= win_lvl)) begin
                win_vld = 1'b1;
                win_num = NUM_W'(i);
                win_lvl = lvl[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/icu_level_stack.sv
// Current priority level with a one-deep save slot.
// A push saves the current level and loads a new one. A pop restores the
// saved level and clears the slot. A push takes precedence over a pop.
module icu_level_stack #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] push_lvl,
    output logic [LVL_W-1:0] cur_lvl,
    output logic [LVL_W-1:0] saved_lvl
);

    // Update the current level and the save slot on acknowledge or restore.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl   <= '0;
            saved_lvl <= '0;
        end else if (push) begin
            saved_lvl <= cur_lvl;
            cur_lvl   <= push_lvl;
        end else if (pop) begin
            cur_lvl   <= saved_lvl;
            saved_lvl <= '0;
        end
    end

endmodule

// File: rtl/prio_intc.sv
// Prioritized interrupt controller, top level.
// Source 0 is the fast pin and drives fiq. Sources 1..N_EXT-1 are
// active-low general pins and are captured on their falling edge.
// Sources N_EXT.. are level-sensitive peripheral requests. Register words:
// level words, then pending, then number (read acknowledges, write
// restores), then current level. Assumes bus_rd and bus_wr are not high
// together.
module prio_intc #(
    parameter int N_EXT_GEN = 8,
    parameter int N_INT     = 19,
    parameter int LVL_W     = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fast_req_n,
    input  logic [N_EXT_GEN-1:0] ext_req_n,
    input  logic [N_INT-1:0]     int_req,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq,
    output logic                 fiq
);

    import prio_intc_pkg::*;

    localparam int N_EXT     = N_EXT_GEN + 1;
    localparam int N_SRC     = N_EXT + N_INT;
    localparam int NUM_W     = $clog2(N_SRC + 1);
    localparam int FLD_W     = LVL_W + 1;
    localparam int FPW       = DATA_W / FLD_W;
    localparam int LVL_WORDS = (N_SRC + FPW - 1) / FPW;
    localparam int A_PEND    = LVL_WORDS;
    localparam int A_NUM     = LVL_WORDS + 1;
    localparam int A_CUR     = LVL_WORDS + 2;
    localparam logic [NUM_W-1:0] NO_WINNER = '1;

    logic [LVL_W-1:0]       lvl_q [N_SRC];
    logic [N_SRC*LVL_W-1:0] lvl_flat;
    logic [N_EXT-1:0]       ext_pend;
    logic [N_EXT-1:0]       ext_fall;
    logic [N_EXT-1:0]       ext_clr;
    logic [N_SRC-1:0]       pend_all;
    logic                   win_vld;
    logic [NUM_W-1:0]       win_num;
    logic [LVL_W-1:0]       win_lvl;
    logic [LVL_W-1:0]       cur_lvl;
    logic [LVL_W-1:0]       saved_lvl;
    logic                   ack;
    logic                   restore;
    reg_kind_t              kind;
    logic                   unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Decode the bus address into a register kind.
    always_comb begin
        if (int'(bus_addr) < LVL_WORDS)   kind = RK_LEVEL;
        else if (int'(bus_addr) == A_PEND) kind = RK_PEND;
        else if (int'(bus_addr) == A_NUM)  kind = RK_NUM;
        else if (int'(bus_addr) == A_CUR)  kind = RK_CUR;
        else                               kind = RK_NONE;
    end

    // Level fields: source s sits in word s/FPW at field s%FPW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < N_SRC; s++) lvl_q[s] <= '0;
        end else if (bus_wr && kind == RK_LEVEL) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (int'(bus_addr) == s / FPW)
                    lvl_q[s] <= bus_wdata[(s % FPW) * FLD_W +: LVL_W];
            end
        end
    end

    // Flatten the level array for the arbiter.
    always_comb begin
        for (int s = 0; s < N_SRC; s++) lvl_flat[s*LVL_W +: LVL_W] = lvl_q[s];
    end

    // Write-one-to-clear strobes for the captured pin requests.
    assign ext_clr = (bus_wr && kind == RK_PEND) ? bus_wdata[N_EXT-1:0] : '0;

    icu_edge_capture #(
        .N (N_EXT)
    ) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n ({ext_req_n, fast_req_n}),
        .clr   (ext_clr),
        .fall  (ext_fall),
        .pend  (ext_pend)
    );

    assign pend_all = {int_req, ext_pend};

    icu_arbiter #(
        .N_SRC (N_SRC),
        .LVL_W (LVL_W),
        .NUM_W (NUM_W),
        .FIRST (1)
    ) u_arbiter (
        .req     (pend_all),
        .lvl     (lvl_flat),
        .win_vld (win_vld),
        .win_num (win_num),
        .win_lvl (win_lvl)
    );

    // Request outputs: irq above the current level, fiq from source 0 alone.
    assign irq = win_vld && (win_lvl > cur_lvl);
    assign fiq = ext_pend[0] && (lvl_q[0] != '0);

    assign ack     = bus_rd && kind == RK_NUM && irq;
    assign restore = bus_wr && kind == RK_NUM;

    icu_level_stack #(
        .LVL_W (LVL_W)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ack),
        .pop       (restore),
        .push_lvl  (win_lvl),
        .cur_lvl   (cur_lvl),
        .saved_lvl (saved_lvl)
    );

    // Read multiplexer, combinational from the address.
    always_comb begin
        bus_rdata = '0;
        unique case (kind)
            RK_LEVEL: begin
                for (int s = 0; s < N_SRC; s++) begin
                    if (int'(bus_addr) == s / FPW)
                        bus_rdata[(s % FPW) * FLD_W +: LVL_W] = lvl_q[s];
                end
            end
            RK_PEND:  bus_rdata[N_SRC-1:0] = pend_all;
            RK_NUM:   bus_rdata[NUM_W-1:0] = irq ? win_num : NO_WINNER;
            RK_CUR:   bus_rdata[LVL_W-1:0] = cur_lvl;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/prio_intc_chk.sv
// Property checker for prio_intc, attached by bind.
// Observes the bus strobes, the arbiter result and the level state.
module prio_intc_chk #(
    parameter int N_EXT  = 9,
    parameter int N_SRC  = 28,
    parameter int LVL_W  = 3,
    parameter int NUM_W  = 5,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int A_PEND = 4,
    parameter int A_NUM  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NUM_W-1:0]  win_num,
    input logic [LVL_W-1:0]  win_lvl,
    input logic [LVL_W-1:0]  cur_lvl,
    input logic [LVL_W-1:0]  saved_lvl,
    input logic [N_EXT-1:0]  ext_pend,
    input logic [N_EXT-1:0]  ext_fall
);

    // R6: an acknowledge loads the winner's level and saves the old one.
    a_r6_ack_loads_level: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && int'(bus_addr) == A_NUM && irq)
        |=> (cur_lvl == $past(win_lvl)) && (saved_lvl == $past(cur_lvl)));

    // R7: a restore write brings back the saved level and empties the slot.
    a_r7_restore_level: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && int'(bus_addr) == A_NUM)
        |=> (cur_lvl == $past(saved_lvl)) && (saved_lvl == '0));

    // R9: a cleared bit stays clear unless an edge arrived on that edge.
    a_r9_clear_wins_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && int'(bus_addr) == A_PEND)
        |=> ((ext_pend & $past(bus_wdata[N_EXT-1:0]) & ~$past(ext_fall)) == '0));

    // R10: the fast source never becomes the irq winner.
    a_r10_num_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (win_num >= NUM_W'(1)) && (int'(win_num) < N_SRC));

    // R6: with no bus strobe at the number register, the current level holds.
    a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !((bus_rd || bus_wr) && int'(bus_addr) == A_NUM) |=> $stable(cur_lvl));

endmodule

bind prio_intc prio_intc_chk #(
    .N_EXT  (N_EXT),
    .N_SRC  (N_SRC),
    .LVL_W  (LVL_W),
    .NUM_W  (NUM_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .A_PEND (A_PEND),
    .A_NUM  (A_NUM)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .win_num   (win_num),
    .win_lvl   (win_lvl),
    .cur_lvl   (cur_lvl),
    .saved_lvl (saved_lvl),
    .ext_pend  (ext_pend),
    .ext_fall  (ext_fall)
);

// File: tb/prio_intc_tb.sv
// Self-checking bench for prio_intc: seeded random level maps and request
// patterns checked against a bench model, plus directed corner cases.
module prio_intc_tb;

    localparam int NS = 28;
    localparam int A_PEND = 4;
    localparam int A_NUM  = 5;
    localparam int A_CUR  = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fast_req_n;
    logic [7:0]  ext_req_n;
    logic [18:0] int_req;
    logic [2:0]  bus_addr;
    logic        bus_wr;
    logic        bus_rd;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        fiq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Bench model state.
    int lvl_m [NS];
    int cur_m = 0;

    always #2.5 clk = ~clk;

    prio_intc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_req_n (fast_req_n),
        .ext_req_n  (ext_req_n),
        .int_req    (int_req),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .fiq        (fiq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected winner number from the model; 31 when irq must be low.
    function automatic int exp_num(input logic [NS-1:0] pend);
        int best = 31;
        int bl = 0;
        for (int s = NS - 1; s >= 1; s--)
            if (pend[s] && lvl_m[s] != 0 && lvl_m[s] >= bl) begin
                best = s;
                bl = lvl_m[s];
            end
        return (best != 31 && bl > cur_m) ? best : 31;
    endfunction

    function automatic int exp_wlvl(input logic [NS-1:0] pend);
        int n = exp_num(pend);
        return (n == 31) ? 0 : lvl_m[n];
    endfunction

    task automatic bus_write(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr = addr[2:0];
        bus_wdata = data;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = addr[2:0];
        #1;
        data = bus_rdata;
    endtask

    task automatic ack_read(output logic [31:0] data);
        @(negedge clk);
        bus_addr = A_NUM[2:0];
        bus_rd = 1'b1;
        #1;
        data = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic write_levels();
        for (int w = 0; w < 4; w++) begin
            logic [31:0] d = '0;
            for (int f = 0; f < 8; f++)
                if (w * 8 + f < NS) d[f*4 +: 3] = lvl_m[w*8 + f][2:0];
            bus_write(w, d);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [NS-1:0] pend_m;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; fast_req_n = 1'b1; ext_req_n = '1; int_req = '0;
        bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
        for (int s = 0; s < NS; s++) lvl_m[s] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state.
        peek(A_NUM, rd);  chk("R1 num", int'(rd), 31);
        peek(A_CUR, rd);  chk("R1 cur", int'(rd), 0);
        peek(A_PEND, rd); chk("R1 pend", int'(rd), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 fiq", int'(fiq), 0);

        // R3 R4 R5 R11: random level maps and peripheral request patterns.
        for (int it = 0; it < 40; it++) begin
            for (int s = 0; s < NS; s++) lvl_m[s] = int'($urandom_range(0, 7));
            write_levels();
            int_req = 19'($urandom & $urandom);
            pend_m = {int_req, 9'd0};
            peek(A_NUM, rd);
            chk("R4 random winner", int'(rd), exp_num(pend_m));
            chk("R5 random irq", int'(irq), int'(exp_num(pend_m) != 31));
            peek(A_PEND, rd);
            chk("R11 pend follows int_req", int'(rd), int'(pend_m));
            if (it % 8 == 0) begin
                peek(it / 8 % 4, rd);
                chk("R3 level readback field", int'(rd[2:0]), lvl_m[(it / 8 % 4) * 8]);
            end
        end

        // R4: tie between int_req[3] (num 12) and int_req[10] (num 19).
        for (int s = 0; s < NS; s++) lvl_m[s] = 0;
        lvl_m[12] = 4; lvl_m[19] = 4;
        write_levels();
        int_req = '0; int_req[3] = 1'b1; int_req[10] = 1'b1; int_req[11] = 1'b1;
        peek(A_NUM, rd); chk("R4 tie lowest number", int'(rd), 12);
        // R3: num 20 requests but has level 0.
        int_req[3] = 1'b0; int_req[10] = 1'b0;
        peek(A_NUM, rd); chk("R3 level zero disabled", int'(rd), 31);
        chk("R3 level zero no irq", int'(irq), 0);
        int_req[3] = 1'b1; int_req[10] = 1'b1;

        // R6: acknowledge raises the current level to 4.
        pend_m = {int_req, 9'd0};
        ack_read(rd); chk("R6 ack returns number", int'(rd), 12);
        cur_m = 4;
        peek(A_CUR, rd); chk("R6 current after ack", int'(rd), 4);
        chk("R5 irq low at equal level", int'(irq), 0);
        peek(A_NUM, rd); chk("R4 number when no irq", int'(rd), 31);
        // R6: read strobe with irq low has no effect.
        ack_read(rd);
        peek(A_CUR, rd); chk("R6 ack ignored when idle", int'(rd), 4);
        // R5: raise num 19 to level 6.
        lvl_m[19] = 6; write_levels();
        chk("R5 irq above current", int'(irq), 1);
        peek(A_NUM, rd); chk("R4 higher level wins", int'(rd), 19);
        ack_read(rd); cur_m = 6;
        peek(A_CUR, rd); chk("R6 nested ack", int'(rd), 6);
        // R7: restores, data ignored.
        bus_write(A_NUM, 32'hFFFF_FFFF);
        peek(A_CUR, rd); chk("R7 first restore", int'(rd), 4);
        bus_write(A_NUM, 32'h0);
        peek(A_CUR, rd); chk("R7 second restore to zero", int'(rd), 0);
        cur_m = 0;
        int_req = '0;

        // R8 R2: edge on ext_req_n[2] (num 3) with level 5.
        for (int s = 0; s < NS; s++) lvl_m[s] = 0;
        lvl_m[3] = 5; lvl_m[6] = 2; write_levels();
        @(negedge clk); ext_req_n[2] = 1'b0;
        @(negedge clk); @(negedge clk); #1;
        chk("R8 not yet pending after two edges", int'(bus_rdata[3] & (bus_addr == A_PEND[2:0])), 0);
        peek(A_PEND, rd); chk("R8 pending after third edge", int'(rd), 32'h8);
        peek(A_NUM, rd); chk("R2 pin 2 is number 3", int'(rd), 3);
        bus_write(A_PEND, 32'h8);
        repeat (3) @(negedge clk);
        peek(A_PEND, rd); chk("R8 held low no re-set", int'(rd), 0);
        chk("R9 clear drops irq", int'(irq), 0);
        ext_req_n[2] = 1'b1;

        // R9: write of zero leaves a bit; collision of clear and edge.
        @(negedge clk); ext_req_n[5] = 1'b0;
        @(posedge clk); @(posedge clk);
        bus_write(A_PEND, 32'h40);
        peek(A_PEND, rd); chk("R9 set wins over clear", int'(rd), 32'h40);
        bus_write(A_PEND, 32'h0);
        peek(A_PEND, rd); chk("R9 zero write no effect", int'(rd), 32'h40);
        bus_write(A_PEND, 32'h40);
        peek(A_PEND, rd); chk("R9 second clear", int'(rd), 0);
        ext_req_n[5] = 1'b1;

        // R11: peripheral pending bit cannot be cleared by a write.
        int_req[0] = 1'b1;
        bus_write(A_PEND, 32'hFFFF_FFFF);
        peek(A_PEND, rd); chk("R11 write ignored", int'(rd), 32'h200);
        int_req[0] = 1'b0;

        // R10: fast pin with level 0, then with level 2.
        @(negedge clk); fast_req_n = 1'b0;
        repeat (4) @(negedge clk);
        peek(A_PEND, rd); chk("R10 fast pending", int'(rd), 1);
        chk("R10 fiq low at level 0", int'(fiq), 0);
        lvl_m[0] = 2; write_levels();
        #1; chk("R10 fiq high", int'(fiq), 1);
        chk("R10 fast not in irq", int'(irq), 0);
        peek(A_NUM, rd); chk("R10 number not fast", int'(rd), 31);
        bus_write(A_PEND, 32'h1);
        #1; chk("R10 fiq cleared", int'(fiq), 0);
        fast_req_n = 1'b1;

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule